// File: doc/BRIEF.md
# Range Table Address Translator

This block turns a virtual address into a physical one by walking a table of mapping ranges kept in memory. Each record in the table describes one contiguous range: where it starts in virtual space, how many bytes it spans, and the physical address that its first byte maps to. The block reads the records one after another. It stops at the first record whose range contains the address, and returns that record's physical address plus the offset of the address into the range.

A record whose virtual start is zero marks the end of the table. Reaching it ends the lookup with a fault. A record count limit also ends the lookup with a fault when no terminator appears in time. The caller pulses `start` with the address and the table base. The block then issues single-word memory reads, one at a time, over a request/valid read port. When the result is ready it pulses `done`, and holds `pa` and `fault` until the next lookup completes.

Top module: `rtr_top`

## Requirements
- R1: A record at byte address A holds three 64-bit words. The virtual start is at A, the span is at A+8 and the physical address is at A+16. Record k of the table sits at table base + 24·k.
- R2: A record whose virtual start reads as zero ends the lookup with `done` and `fault` high.
- R3: A record covers the address when start ≤ address and address < start + span. Both comparisons are unsigned, and start + span is taken without wrap-around. The lower bound is inclusive and the upper bound is exclusive.
- R4: On a covering record, `pa` = physical word + (address − start) modulo 2^64, and `fault` is low.
- R5: Records are tried in table order, and the first covering record decides the result.
- R6: When the address is below a record's start, neither of that record's other words is read. When the address is at or beyond start + span, the physical word is not read.
- R7: When MAX_REC records have been tried without a cover and without a terminator, the lookup ends with `fault` high. A cover in record MAX_REC−1 still succeeds.
- R8: At most one read is outstanding. `rd_req` is a one-cycle pulse, and it is not raised again until `rd_valid` has returned the previous word.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse. `pa` and `fault` hold their values until the next lookup completes.
- R10: A `start` pulse while `busy` is high is ignored, and the running lookup completes with its own address.
- R11: After reset, `busy`, `done`, `fault`, `rd_req` and `pa` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (accepted when idle) |
| va | input | 64 | Virtual address to translate |
| tbl_base | input | 64 | Byte address of the first record |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last lookup found no covering record |
| pa | output | 64 | Translated address of the last lookup (zero on fault) |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Returned word |

## Verification
The assertions watch properties that hold on every cycle:
- the read port never pulses `rd_req` twice in a row;
- `done` never lasts two cycles;
- a terminator or a cover is always followed by the matching fault value;
- the record counter stays under its limit;
- the latched address and the results stay stable while they must.

Only the bench scenarios can show that the result is correct. A reference walk of the same memory image predicts the exact sequence of word addresses and the expected result. Against that prediction the scenarios check:
- the inclusive and exclusive range bounds;
- unsigned comparison near the top of the address space;
- first-match order between overlapping records;
- the skipped reads;
- the record limit;
- that a restart is ignored under varied read latency.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [1:0] {W_BASE = 2'd0, W_SPAN = 2'd1, W_PHYS = 2'd2} word_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_REQ = 2'd1, S_WAIT = 2'd2} state_e;
  typedef struct packed {
    logic term;     // start word is zero
    logic below;    // address under the start word
    logic outside;  // address at or past start + span
  } verdict_t;
endpackage

// File: rtl/rtr_addr.sv
module rtr_addr #(
  parameter int AW = 64
) (
  input  logic [AW-1:0]       rec_ptr,
  input  rtr_pkg::word_e      kind,
  output logic [AW-1:0]       word_addr
);
  import rtr_pkg::*;
  localparam int WB = AW / 8;

  function automatic logic [AW-1:0] f_word_offset(input word_e k);
    case (k)
      W_BASE:  return '0;
      W_SPAN:  return AW'(WB);
      default: return AW'(2 * WB);
    endcase
  endfunction

  assign word_addr = rec_ptr + f_word_offset(kind);
endmodule

// File: rtl/rtr_eval.sv
module rtr_eval #(
  parameter int AW = 64
) (
  input  logic [AW-1:0]       data,
  input  logic [AW-1:0]       va,
  input  logic [AW-1:0]       base,
  output rtr_pkg::verdict_t   verdict,
  output logic [AW-1:0]       xlate
);
  import rtr_pkg::*;

  function automatic logic f_below(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a < b;
  endfunction

  // exclusive upper bound computed one bit wider so the sum cannot wrap
  function automatic logic f_outside(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                     input logic [AW-1:0] span);
    logic [AW:0] lim;
    lim = {1'b0, b} + {1'b0, span};
    return {1'b0, a} >= lim;
  endfunction

  function automatic logic [AW-1:0] f_xlate(input logic [AW-1:0] phys, input logic [AW-1:0] a,
                                            input logic [AW-1:0] b);
    return phys + (a - b);
  endfunction

  always_comb begin
    verdict.term    = (data == '0);
    verdict.below   = f_below(va, data);
    verdict.outside = f_outside(va, base, data);
    xlate           = f_xlate(data, va, base);
  end
endmodule

// File: rtl/rtr_seq.sv
module rtr_seq #(
  parameter int AW      = 64,
  parameter int MAX_REC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       va,
  input  logic [AW-1:0]       tbl_base,
  input  logic                rd_valid,
  input  logic [AW-1:0]       rd_data,
  input  rtr_pkg::verdict_t   verdict,
  input  logic [AW-1:0]       xlate,
  output rtr_pkg::word_e      kind,
  output logic [AW-1:0]       rec_ptr,
  output logic [AW-1:0]       va_q,
  output logic [AW-1:0]       base_q,
  output logic                req,
  output logic                busy,
  output logic                done_q,
  output logic                fault_q,
  output logic [AW-1:0]       pa_q
);
  import rtr_pkg::*;
  localparam int STRIDE = 3 * (AW / 8);
  localparam int CW     = $clog2(MAX_REC + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_REC - 1);

  state_e        st;
  logic [CW-1:0] cnt;

  // named events for assertions
  logic arrive, ev_term, ev_skip, ev_limit, ev_hit, ev_adv, ev_finish;
  assign arrive    = (st == S_WAIT) && rd_valid;
  assign ev_term   = arrive && (kind == W_BASE) && verdict.term;
  assign ev_skip   = arrive && (((kind == W_BASE) && !verdict.term && verdict.below) ||
                                ((kind == W_SPAN) && verdict.outside));
  assign ev_limit  = ev_skip && (cnt == LAST);
  assign ev_hit    = arrive && (kind == W_PHYS);
  assign ev_adv    = arrive && (((kind == W_BASE) && !verdict.term && !verdict.below) ||
                                ((kind == W_SPAN) && !verdict.outside));
  assign ev_finish = ev_term || ev_limit || ev_hit;

  assign req  = (st == S_REQ);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= W_BASE;
      rec_ptr <= '0;
      va_q    <= '0;
      base_q  <= '0;
      cnt     <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q    <= va;
          rec_ptr <= tbl_base;
          kind    <= W_BASE;
          cnt     <= '0;
          st      <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (ev_finish) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            fault_q <= !ev_hit;
            pa_q    <= ev_hit ? xlate : '0;
          end else if (ev_skip) begin
            cnt     <= cnt + 1'b1;
            rec_ptr <= rec_ptr + AW'(STRIDE);
            kind    <= W_BASE;
            st      <= S_REQ;
          end else if (ev_adv) begin
            if (kind == W_BASE) begin
              base_q <= rd_data;
              kind   <= W_SPAN;
            end else begin
              kind   <= W_PHYS;
            end
            st <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a request is never followed directly by another
  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2: a terminator record ends with a fault
  a_r2_term_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ev_term |=> done_q && fault_q);
  // R4: a physical word arrival completes without fault
  a_r4_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> done_q && !fault_q);
  // R7: record counter never passes the limit
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R10: a running lookup keeps its own address
  a_r10_va_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(va_q));
  // R9: results hold while idle
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> $stable(pa_q) && $stable(fault_q));
endmodule

// File: rtl/rtr_top.sv
module rtr_top #(
  parameter int AW      = 64,
  parameter int MAX_REC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] tbl_base,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] pa,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_data
);
  import rtr_pkg::*;

  word_e         kind;
  verdict_t      verdict;
  logic [AW-1:0] rec_ptr, va_q, base_q, xlate;

  rtr_addr #(.AW(AW)) u_addr (
    .rec_ptr  (rec_ptr),
    .kind     (kind),
    .word_addr(rd_addr)
  );

  rtr_eval #(.AW(AW)) u_eval (
    .data   (rd_data),
    .va     (va_q),
    .base   (base_q),
    .verdict(verdict),
    .xlate  (xlate)
  );

  rtr_seq #(.AW(AW), .MAX_REC(MAX_REC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .va      (va),
    .tbl_base(tbl_base),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .verdict (verdict),
    .xlate   (xlate),
    .kind    (kind),
    .rec_ptr (rec_ptr),
    .va_q    (va_q),
    .base_q  (base_q),
    .req     (rd_req),
    .busy    (busy),
    .done_q  (done),
    .fault_q (fault),
    .pa_q    (pa)
  );

  // R11: quiet outputs in the cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !rd_req && !fault && (pa == '0));
endmodule

// File: tb/tb_rtr_top.sv
`timescale 1ns/1ps
module tb_rtr_top;
  localparam int MAXR = 8;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] va = '0, tbl_base = '0;
  logic        busy, done, fault, rd_req;
  logic [63:0] pa, rd_addr;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  rtr_top #(.AW(64), .MAX_REC(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .tbl_base(tbl_base),
    .busy(busy), .done(done), .fault(fault), .pa(pa),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  logic [63:0] mem [logic [63:0]];
  int checks = 0, errors = 0;
  logic [63:0] exp_q [$];
  logic [63:0] exp_pa;
  logic        exp_fault;
  logic        pend = 1'b0, prev_done = 1'b0;
  int          pcnt = 0, lat_sel = 0;
  logic [63:0] paddr = '0;

  function automatic logic [63:0] mread(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic put_rec(input logic [63:0] tb, input int idx, input logic [63:0] b,
                         input logic [63:0] s, input logic [63:0] p);
    logic [63:0] a;
    a = tb + 64'(24 * idx);
    mem[a] = b; mem[a + 8] = s; mem[a + 16] = p;
  endtask

  // reference walk: word addresses in order plus the outcome
  task automatic predict(input logic [63:0] tb, input logic [63:0] v);
    exp_q.delete();
    exp_fault = 1'b1;
    exp_pa    = '0;
    for (int i = 0; i < MAXR; i++) begin
      logic [63:0] a, b, s;
      logic [64:0] lim;
      a = tb + 64'(24 * i);
      exp_q.push_back(a);
      b = mread(a);
      if (b == 0) return;
      if (v < b) continue;
      exp_q.push_back(a + 8);
      s = mread(a + 8);
      lim = {1'b0, b} + {1'b0, s};
      if ({1'b0, v} >= lim) continue;
      exp_q.push_back(a + 16);
      exp_pa = mread(a + 16) + (v - b);
      exp_fault = 1'b0;
      return;
    end
  endtask

  // per-cycle compare against the reference, plus the memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req) chk(!pend, "R8", "request while read pending", 64'(rd_req), 64'h0);
      if (done && prev_done) chk(1'b0, "R9", "done longer than one cycle", 64'h1, 64'h0);
      prev_done = done;
      rd_valid = 1'b0;
      if (pend && pcnt == 0) begin
        rd_valid = 1'b1;
        rd_data  = mread(paddr);
        pend     = 1'b0;
      end else if (pend) pcnt--;
      if (rd_req) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected read", rd_addr, 64'h0);
        else begin
          chk(rd_addr == exp_q[0], "R1", "read address", rd_addr, exp_q[0]);
          void'(exp_q.pop_front());
        end
        pend = 1'b1; paddr = rd_addr; pcnt = lat_sel;
        lat_sel = (lat_sel + 1) % 4;
      end
    end
  end

  task automatic run(input logic [63:0] tb, input logic [63:0] v, input bit restart,
                     input logic [63:0] v2, input string req);
    int n;
    logic [63:0] hold_pa;
    predict(tb, v);
    @(negedge clk); tbl_base = tb; va = v; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R9", "busy after start", 64'(busy), 64'h1);
    if (restart) begin
      @(negedge clk); va = v2; tbl_base = tb + 24; start = 1'b1;  // R10
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, req, "lookup completes", 64'(n), 64'h0);
    chk(fault == exp_fault, req, "fault", 64'(fault), 64'(exp_fault));
    chk(pa == exp_pa, req, "translated address", pa, exp_pa);
    chk(exp_q.size() == 0, "R6", "reads left unissued", 64'(exp_q.size()), 64'h0);
    hold_pa = pa;
    @(negedge clk); @(negedge clk);
    chk(!busy && pa == hold_pa, "R9", "result held after done", pa, hold_pa);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // table A
    put_rec(64'h1000, 0, 64'h4000, 64'h1000, 64'h9000_0000);
    put_rec(64'h1000, 1, 64'h10000, 64'h8000, 64'hA000_0000);
    put_rec(64'h1000, 2, 64'h8000, 64'h100, 64'hB000_0000);
    put_rec(64'h1000, 3, 64'h0, 64'h0, 64'h0);
    // table B: overlapping ranges
    put_rec(64'h2000, 0, 64'h20000, 64'h1000, 64'hC000_0000);
    put_rec(64'h2000, 1, 64'h20000, 64'h10000, 64'hD000_0000);
    put_rec(64'h2000, 2, 64'h0, 64'h0, 64'h0);
    // table C: range near the top, start + span exceeds 64 bits
    put_rec(64'h3000, 0, 64'hF000_0000_0000_0000, 64'h2000_0000_0000_0000, 64'h1234_0000);
    put_rec(64'h3000, 1, 64'h0, 64'h0, 64'h0);
    // table D: no early terminator
    for (int i = 0; i < MAXR + 2; i++)
      put_rec(64'h4000, i, 64'(256 * (i + 1)), 64'h10, 64'(32'h5000_0000 + 4096 * i));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !rd_req && pa == 0, "R11", "reset state",
        {busy, done, fault, rd_req}, 64'h0);

    run(64'h1000, 64'h4000, 1'b0, 0, "R3");             // inclusive lower bound
    run(64'h1000, 64'h4FFF, 1'b0, 0, "R4");             // last byte
    run(64'h1000, 64'h5000, 1'b0, 0, "R2");             // exclusive upper, terminator
    run(64'h1000, 64'h12345, 1'b0, 0, "R4");            // second record
    run(64'h1000, 64'h3FFF, 1'b0, 0, "R6");             // below all starts
    run(64'h2000, 64'h20800, 1'b0, 0, "R5");            // first of overlapping
    run(64'h2000, 64'h22000, 1'b0, 0, "R5");            // only second covers
    run(64'h3000, 64'hF800_0000_0000_0000, 1'b0, 0, "R3");  // no wrap of bound
    run(64'h3000, 64'h10, 1'b0, 0, "R3");               // unsigned below start
    run(64'h4000, 64'h50, 1'b0, 0, "R7");               // limit reached
    run(64'h4000, 64'h805, 1'b0, 0, "R7");              // last allowed record
    run(64'h4000, 64'h905, 1'b0, 0, "R7");              // beyond the limit
    run(64'h1000, 64'h12345, 1'b1, 64'h4000, "R10");    // restart ignored

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule